// File: doc/BRIEF.md
# Sparse Row Position Encoder

This block turns one 8x8 binary block into a serial bit stream that is cheap when the block has few set bits. The block arrives as a 64-bit word together with a start pulse. Bit `r*8+c` is the cell in row `r` and column `c`. The encoder walks the rows from top to bottom. For each row it sends either a single zero, meaning the row is empty, or a sequence of tokens, one for each set cell.

Each token is a marker `1` followed by a position field, and its width depends on the token's place in the row:

- The first token of a row carries the absolute column in three bits.
- Every later token carries the number of clear cells skipped since the previous set cell. Its field is only as wide as the columns still to the right of that cell can require.

Fields are sent MSB first. A closing `0` ends each row that holds set cells, except when the last set cell is in column 7.

Output bits leave one at a time through a valid/ready pair. A one-cycle done pulse follows the final bit of the block.

Top module: `sparse_row_pos_enc`

## Requirements
- R1: A row with no set cell produces exactly one output bit, `0`.
- R2: Each set cell produces a marker bit `1` and then a field. For the first set cell of a row, the field is the column index as three bits, MSB first.
- R3: For a later set cell at column `p`, whose previous set cell is at column `q`, the field carries `p-q-1`. Its width is the smallest `w` with `2^w >= 7-q`, and it is sent MSB first.
- R4: When the previous set cell is in column 6 and column 7 is set, the marker `1` for column 7 is followed by no field bits.
- R5: After the last set cell of a row the encoder emits one `0`. When that last set cell is in column 7, no `0` is emitted for the row.
- R6: Rows are coded in order 0 to 7, and set cells within a row in ascending column order. Input bit `r*8+c` is row `r`, column `c`.
- R7: One bit is transferred on each clock edge where `enc_valid` and `enc_ready` are both high. While `enc_valid` is high and `enc_ready` is low, `enc_valid` and `enc_bit` hold their values.
- R8: `blk_done` is high for exactly one cycle. That cycle is the one directly after the edge that transfers the block's last bit, and `enc_valid` is low during it.
- R9: The block word is captured on the accepted start. While a block is in progress, `start` and changes on `blk_bits` have no effect on the stream.
- R10: After reset, `enc_valid` and `blk_done` are low and stay low until a start is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin coding `blk_bits`; honoured only when idle |
| blk_bits | input | 64 | Block, bit `r*8+c` = row r, column c |
| enc_valid | output | 1 | Output bit present |
| enc_bit | output | 1 | Output bit value |
| enc_ready | input | 1 | Downstream accepts the bit this cycle |
| blk_done | output | 1 | One-cycle pulse after the last bit of the block |

## Verification
A wrong column base or a stale previous-column register shows up as a wrong field width. The stream is then shifted for the remainder of the block, so the bench catches it within a few bits of the faulty token and again as a wrong total bit count. A row counter that advances at the wrong moment shows as a missing or extra row terminator, and as a done pulse that does not fall on the cycle after the last transfer. A stall-handling fault shows at the first cycle with `enc_ready` low, as a changed or dropped bit.

// File: rtl/srpe_pkg.sv
package srpe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_MARK,
    ST_FIELD,
    ST_EOR,
    ST_FIN
  } srpe_state_e;
endpackage

// File: rtl/srpe_rst_sync.sv
module srpe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/srpe_next_one.sv
module srpe_next_one #(
  parameter int COLS = 8,
  parameter int CW   = $clog2(COLS)
) (
  input  logic [COLS-1:0] row_bits,
  input  logic [CW:0]     from_col,
  output logic            found,
  output logic [CW-1:0]   col
);
  // lowest set column at or above from_col
  always_comb begin
    found = 1'b0;
    col   = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (row_bits[c] && (c >= int'(from_col))) begin
        found = 1'b1;
        col   = CW'(c);
      end
    end
  end

  always_comb begin
    if (found) begin
      AST_FIND_HIT: assert (row_bits[col] && ({1'b0, col} >= from_col)); // R6
    end
  end
endmodule

// File: rtl/srpe_field_width.sv
module srpe_field_width #(
  parameter int COLS = 8,
  parameter int CW   = $clog2(COLS)
) (
  input  logic          first,
  input  logic [CW-1:0] prev_col,
  output logic [CW:0]   width
);
  int rem;

  always_comb begin
    rem   = COLS - 1 - int'(prev_col);
    width = '0;
    if (first) begin
      width = (CW + 1)'(CW);
    end else begin
      for (int k = 0; k <= CW; k++) begin
        if ((1 << k) < rem) width = (CW + 1)'(k + 1);
      end
    end
  end
endmodule

// File: rtl/sparse_row_pos_enc.sv
module sparse_row_pos_enc
  import srpe_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start,
  input  logic [ROWS*COLS-1:0] blk_bits,
  output logic                 enc_valid,
  output logic                 enc_bit,
  input  logic                 enc_ready,
  output logic                 blk_done
);
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);

  logic rst_n;

  srpe_state_e          state_q, state_d;
  logic [ROWS*COLS-1:0] blk_q;
  logic                 load_en;
  logic [RW-1:0]        row_q, row_d;
  logic [CW:0]          base_q, base_d;
  logic [CW-1:0]        prev_q, prev_d;
  logic                 first_q, first_d;
  logic [CW-1:0]        pos_q, pos_d;
  logic [CW-1:0]        val_q, val_d;
  logic [CW:0]          wid_q, wid_d;
  logic [CW-1:0]        cnt_q, cnt_d;

  logic [COLS-1:0]      cur_row;
  logic                 hit;
  logic [CW-1:0]        hit_col;
  logic [CW:0]          hit_wid;
  logic                 one_done, row_done;

  srpe_rst_sync #(.STAGES(2)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_n)
  );

  assign cur_row = blk_q[int'(row_q)*COLS +: COLS];

  srpe_next_one #(.COLS(COLS), .CW(CW)) u_find (
    .row_bits(cur_row),
    .from_col(base_q),
    .found   (hit),
    .col     (hit_col)
  );

  srpe_field_width #(.COLS(COLS), .CW(CW)) u_wid (
    .first   (first_q),
    .prev_col(prev_q),
    .width   (hit_wid)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    row_d     = row_q;
    base_d    = base_q;
    prev_d    = prev_q;
    first_d   = first_q;
    pos_d     = pos_q;
    val_d     = val_q;
    wid_d     = wid_q;
    cnt_d     = cnt_q;
    load_en   = 1'b0;
    enc_valid = 1'b0;
    enc_bit   = 1'b0;
    one_done  = 1'b0;
    row_done  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          row_d   = '0;
          base_d  = '0;
          prev_d  = '0;
          first_d = 1'b1;
          state_d = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (hit) begin
          pos_d   = hit_col;
          wid_d   = hit_wid;
          val_d   = first_q ? hit_col : (hit_col - prev_q - CW'(1));
          state_d = ST_MARK;
        end else begin
          state_d = ST_EOR;
        end
      end
      ST_MARK: begin
        enc_valid = 1'b1;
        enc_bit   = 1'b1;
        if (enc_ready) begin
          if (wid_q == '0) begin
            one_done = 1'b1;
          end else begin
            cnt_d   = CW'(wid_q - 1'b1);
            state_d = ST_FIELD;
          end
        end
      end
      ST_FIELD: begin
        enc_valid = 1'b1;
        enc_bit   = val_q[cnt_q];
        if (enc_ready) begin
          if (cnt_q == '0) one_done = 1'b1;
          else             cnt_d    = cnt_q - CW'(1);
        end
      end
      ST_EOR: begin
        enc_valid = 1'b1;
        enc_bit   = 1'b0;
        if (enc_ready) row_done = 1'b1;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    if (one_done) begin
      if (pos_q == CW'(COLS - 1)) begin
        row_done = 1'b1;
      end else begin
        base_d  = (CW + 1)'(pos_q) + (CW + 1)'(1);
        prev_d  = pos_q;
        first_d = 1'b0;
        state_d = ST_SCAN;
      end
    end

    if (row_done) begin
      if (row_q == RW'(ROWS - 1)) begin
        state_d = ST_FIN;
      end else begin
        row_d   = row_q + RW'(1);
        base_d  = '0;
        prev_d  = '0;
        first_d = 1'b1;
        state_d = ST_SCAN;
      end
    end
  end

  assign blk_done = (state_q == ST_FIN);

  // control registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      base_q  <= '0;
      prev_q  <= '0;
      first_q <= 1'b1;
      pos_q   <= '0;
      val_q   <= '0;
      wid_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      base_q  <= base_d;
      prev_q  <= prev_d;
      first_q <= first_d;
      pos_q   <= pos_d;
      val_q   <= val_d;
      wid_q   <= wid_d;
      cnt_q   <= cnt_d;
    end
  end

  // block capture, enable only
  always_ff @(posedge clk_i) begin
    if (load_en) blk_q <= blk_bits;
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    enc_valid && !enc_ready |=> enc_valid && $stable(enc_bit)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n)
    blk_done |=> !blk_done); // R8

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    blk_done |-> !enc_valid); // R8

  AST_BLOCK_HELD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(blk_q)); // R9

  AST_EMPTY_FIELD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_MARK) && (wid_q == '0) |->
      !first_q && (prev_q == CW'(COLS - 2)) && (pos_q == CW'(COLS - 1))); // R4

  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !enc_valid && !blk_done); // R10
endmodule

// File: tb/tb_sparse_row_pos_enc.sv
module tb_sparse_row_pos_enc;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start;
  logic [63:0] blk_bits;
  logic        enc_valid, enc_bit, enc_ready, blk_done;

  int nchk = 0;
  int nfail = 0;

  logic exp_bits [0:255];
  int   exp_n;
  logic got_bits [0:255];
  int   got_n;
  int   mism;
  int   done_cnt, done_cyc, last_cyc;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  sparse_row_pos_enc dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start    (start),
    .blk_bits (blk_bits),
    .enc_valid(enc_valid),
    .enc_bit  (enc_bit),
    .enc_ready(enc_ready),
    .blk_done (blk_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic b);
    exp_bits[exp_n] = b;
    exp_n++;
  endtask

  // reference stream built from the requirements
  task automatic model(input logic [63:0] b);
    int prev, last, w, v, rem;
    bit first;
    exp_n = 0;
    for (int r = 0; r < 8; r++) begin
      prev = 0; first = 1; last = -1;
      for (int c = 0; c < 8; c++) begin
        if (b[r*8+c]) begin
          push(1'b1);
          if (first) begin
            w = 3; v = c;
          end else begin
            rem = 7 - prev; w = 0;
            while ((1 << w) < rem) w++;
            v = c - prev - 1;
          end
          for (int k = w - 1; k >= 0; k--) push(v[k]);
          prev = c; first = 0; last = c;
        end
      end
      if (last != 7) push(1'b0);
    end
  endtask

  // mode 0: ready high, 1: pseudo-random ready, 2: random ready plus start while busy
  task automatic run(input logic [63:0] b, input int mode, input logic [63:0] other,
                     input string req);
    int tail;
    model(b);
    got_n = 0; mism = 0; done_cnt = 0; done_cyc = -1; last_cyc = -1; tail = -1;
    @(negedge clk_i);
    blk_bits = b; start = 1'b1;
    @(negedge clk_i);
    start = 1'b0; blk_bits = ~b;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      enc_ready = (mode == 0) ? 1'b1 : lfsr[0] | lfsr[3];
      if (mode == 2 && (cyc == 4 || cyc == 9)) begin
        start = 1'b1; blk_bits = other;
      end else begin
        start = 1'b0;
      end
      #1;
      if (blk_done) begin
        done_cnt++; done_cyc = cyc;
        if (tail < 0) tail = cyc + 3;
      end
      if (enc_valid && enc_ready) begin
        if (got_n < 256) begin
          got_bits[got_n] = enc_bit;
          if (got_n >= exp_n || enc_bit !== exp_bits[got_n]) mism++;
        end
        got_n++; last_cyc = cyc;
      end
      if (tail >= 0 && cyc >= tail) break;
      @(negedge clk_i);
    end
    start = 1'b0; enc_ready = 1'b0;
    check(mism == 0, req, "stream bit mismatches", mism, 0);
    check(got_n == exp_n, req, "stream length", got_n, exp_n);
    check(done_cnt == 1 && done_cyc == last_cyc + 1, "R8", "done cycle",
          done_cyc, last_cyc + 1);
  endtask

  task automatic check_lit(input logic [63:0] lit, input int len, input string req);
    int bad = 0;
    for (int i = 0; i < len; i++)
      if (i >= got_n || got_bits[i] !== lit[len-1-i]) bad++;
    check(bad == 0 && got_n == len, req, "literal stream bits wrong", bad, 0);
  endtask

  task automatic t_reset;
    enc_ready = 1'b1;
    repeat (5) begin
      @(negedge clk_i);
      check(!enc_valid && !blk_done, "R10", "idle outputs after reset",
            int'(enc_valid) + int'(blk_done), 0);
    end
    enc_ready = 1'b0;
  endtask

  task automatic t_all_zero;
    run(64'h0, 0, 64'h0, "R1");
    check_lit(64'h0, 8, "R1");
  endtask

  task automatic t_example_row;
    run((64'h1 << 19) | (64'h1 << 21) | (64'h1 << 22), 0, 64'h0, "R3");
    check_lit(64'b00101110110000000, 17, "R2");
  endtask

  task automatic t_col7;
    run((64'h1 << 6) | (64'h1 << 7) | (64'h1 << 15), 0, 64'h0, "R4");
    check_lit(64'b111011111000000, 15, "R5");
  endtask

  task automatic t_all_ones;
    run(64'hFFFF_FFFF_FFFF_FFFF, 0, 64'h0, "R6");
    check(got_n == 200, "R6", "dense block length", got_n, 200);
  endtask

  task automatic t_backpressure;
    run(64'h8142_2418_0000_A501, 1, 64'h0, "R7");
    run(64'h0123_4567_89AB_CDEF, 1, 64'h0, "R3");
  endtask

  task automatic t_busy_start;
    run(64'h0080_0001_4000_0200, 2, 64'hFFFF_0000_FFFF_0000, "R9");
  endtask

  initial begin
    rst_ni = 1'b0; start = 1'b0; blk_bits = '0; enc_ready = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    t_reset();
    t_all_zero();
    t_example_row();
    t_col7();
    t_all_ones();
    t_backpressure();
    t_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    nchk++; nfail++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule